// File: doc/BRIEF.md
# Circular Trace Capture Buffer

The block records a run of trace words into a ring memory of 64 entries, each 20 bits wide. While the block is armed it accepts one word for each valid/ready transfer on its trace stream input. It writes the word at the slot given by a running 6-bit count and then increments that count. The count, together with a sticky full flag, shows software how much of the ring holds valid data. A plain read port returns any stored entry by index. Reading an entry never changes the count.

There are two alignment modes. In begin alignment the capture stops once all 64 entries are written: the block disarms itself and the ring is kept as it is. In end alignment the count wraps and capture goes on, and each new word replaces the oldest one. When the ring is full, the oldest entry sits at the slot the count points to. A system reset ends any capture session but leaves the count, the flag and the stored words intact. Only a power-on reset clears the count and the flag.

The trace input follows a valid/ready handshake. `trc_ready` is high only while the block is armed and no arm request is present in the same cycle. A word is taken on a clock edge where both `trc_valid` and `trc_ready` are high. While `trc_ready` is low, no word is taken: a source that has to keep every word holds it, and a source that is sampling live trace may drop it. The status outputs are read-only. There is no input that writes them.

Top module: `trace_ring_capture`

## Requirements
- R1: On a transfer (`trc_valid` and `trc_ready` high at a clock edge), the word is stored at the slot equal to the count, and the count increments by one.
- R2: While the block is not armed, `trc_ready` is low. Words offered on the input are then ignored: the count and the stored entries do not change.
- R3: `status_cnt` bits 5..0 hold the count of valid entries, bit 6 reads 0, and bit 7 holds the full flag.
- R4: When a transfer rolls the count from 63 to 0, the full flag is set. The flag stays set until the next arm request or a power-on reset.
- R5: In begin alignment (`align_end`=0), the 64th transfer of a session also clears the armed state. Later offered words are ignored.
- R6: In end alignment (`align_end`=1), capture continues after rollover and overwrites the oldest entries. `oldest_idx` equals the count while the flag is set, and 0 otherwise.
- R7: `arm_set` clears the count and the full flag and arms the block. `arm_clr` disarms the block and leaves the count and the flag as they are.
- R8: While `sys_rst_n` is low, the block is disarmed and `arm_set` is ignored. The count, the full flag and the stored entries keep their values.
- R9: While `por_n` is low, the count and the full flag are 0 and the block is disarmed.
- R10: `rd_data` returns the entry at `rd_addr`. Reading has no effect on the count.
- R11: `status_aux` bit 7 mirrors the full flag, and its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low; disarms only |
| arm_set | input | 1 | Arm request; clears count and full flag |
| arm_clr | input | 1 | Disarm request |
| align_end | input | 1 | 1 = end alignment (wrap), 0 = begin alignment (stop when full) |
| trc_valid | input | 1 | Trace word valid |
| trc_ready | output | 1 | Block accepts a trace word |
| trc_data | input | 20 | Trace word |
| rd_addr | input | 6 | Read slot index |
| rd_data | output | 20 | Entry stored at `rd_addr` |
| status_cnt | output | 8 | Full flag in bit 7, count in bits 5..0 |
| status_aux | output | 8 | Full flag in bit 7, other bits 0 |
| oldest_idx | output | 6 | Slot of the oldest valid entry |
| armed | output | 1 | Capture session active |

## Verification
The bench runs the capture path with several input patterns. A begin-aligned fill of exactly 64 words, followed by more offered words, separates stop-on-full from wrap behaviour. A 70-word end-aligned run shows whether the count rolls over, whether the flag stays set, and whether slots 0..5 now hold the newest words while slot 6 holds the oldest. A short session ended by `arm_clr`, and words offered while idle, show that the count and the contents stay unchanged without a handshake. Resets raised in the middle of a session show that a system reset keeps the count, the flag and the stored data, and that a power-on reset clears the count and the flag.

// File: rtl/trace_ring_pkg.sv
package trace_ring_pkg;
  typedef enum logic {
    ALIGN_BEGIN = 1'b0,
    ALIGN_END   = 1'b1
  } align_e;
endpackage

// File: rtl/trace_ring_store.sv
module trace_ring_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 20
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  // The ring is not reset on purpose: its contents must survive every reset.
  logic [DATA_W-1:0] ring_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ring_q[waddr] <= wdata;
  end

  assign rdata = ring_q[raddr];
endmodule

// File: rtl/trace_fill_ctrl.sv
module trace_fill_ctrl
  import trace_ring_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              arm_set,
  input  logic              arm_clr,
  input  align_e            align,
  input  logic              trc_valid,
  output logic              take,
  output logic              ready,
  output logic [ADDR_W-1:0] cnt,
  output logic              full,
  output logic              armed
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  logic arm_ok;
  logic wrap;
  logic sess_rst_n;

  assign arm_ok     = arm_set & sys_rst_n;
  assign ready      = armed & ~arm_ok;
  assign take       = ready & trc_valid;
  assign wrap       = take & (cnt == LAST);
  assign sess_rst_n = por_n & sys_rst_n;

  // Count and full flag: cleared only by power-on reset or an arm request.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt  <= '0;
      full <= 1'b0;
    end else if (arm_ok) begin
      cnt  <= '0;
      full <= 1'b0;
    end else if (take) begin
      cnt <= cnt + 1'b1;
      if (wrap) full <= 1'b1;
    end
  end

  // Session state: ended by either reset.
  always_ff @(posedge clk or negedge sess_rst_n) begin
    if (!sess_rst_n) begin
      armed <= 1'b0;
    end else if (arm_ok) begin
      armed <= 1'b1;
    end else if (arm_clr) begin
      armed <= 1'b0;
    end else if (wrap && align == ALIGN_BEGIN) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/trace_ring_capture.sv
module trace_ring_capture
  import trace_ring_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 20
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              arm_set,
  input  logic              arm_clr,
  input  logic              align_end,
  input  logic              trc_valid,
  output logic              trc_ready,
  input  logic [DATA_W-1:0] trc_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W+1:0] status_cnt,
  output logic [7:0]        status_aux,
  output logic [ADDR_W-1:0] oldest_idx,
  output logic              armed
);
  logic              take;
  logic [ADDR_W-1:0] cnt;
  logic              full;
  align_e            align;

  assign align = align_e'(align_end);

  trace_fill_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .por_n     (por_n),
    .sys_rst_n (sys_rst_n),
    .arm_set   (arm_set),
    .arm_clr   (arm_clr),
    .align     (align),
    .trc_valid (trc_valid),
    .take      (take),
    .ready     (trc_ready),
    .cnt       (cnt),
    .full      (full),
    .armed     (armed)
  );

  trace_ring_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .we    (take),
    .waddr (cnt),
    .wdata (trc_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  assign status_cnt = {full, 1'b0, cnt};
  assign status_aux = {full, 7'b0};
  assign oldest_idx = full ? cnt : '0;
endmodule

// File: rtl/trace_ring_checker.sv
module trace_ring_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              por_n,
  input logic              sys_rst_n,
  input logic              arm_set,
  input logic              align_end,
  input logic              trc_valid,
  input logic              trc_ready,
  input logic [ADDR_W+1:0] status_cnt,
  input logic              armed
);
  logic [ADDR_W-1:0] c;
  logic              f;
  assign c = status_cnt[ADDR_W-1:0];
  assign f = status_cnt[ADDR_W+1];

  p_idle_not_ready_r2: assert property (@(posedge clk) disable iff (!por_n)
    !armed |-> !trc_ready);

  p_count_step_r1: assert property (@(posedge clk) disable iff (!por_n)
    (trc_valid && trc_ready) |=> c == $past(c) + 1'b1);

  p_full_sticky_r4: assert property (@(posedge clk) disable iff (!por_n)
    (f && !arm_set) |=> f);

  p_begin_stop_r5: assert property (@(posedge clk) disable iff (!por_n)
    (trc_valid && trc_ready && !align_end && c == {ADDR_W{1'b1}}) |=> (!armed && f));

  p_arm_clear_r7: assert property (@(posedge clk) disable iff (!por_n)
    (arm_set && sys_rst_n) |=> (c == '0 && !f && armed));

  p_sysrst_keep_r8: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |=> ($stable(status_cnt) && !armed));
endmodule

bind trace_ring_capture trace_ring_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .sys_rst_n  (sys_rst_n),
  .arm_set    (arm_set),
  .align_end  (align_end),
  .trc_valid  (trc_valid),
  .trc_ready  (trc_ready),
  .status_cnt (status_cnt),
  .armed      (armed)
);

// File: tb/test_trace_ring_capture.sv
module test_trace_ring_capture;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic        arm_set = 1'b0;
  logic        arm_clr = 1'b0;
  logic        align_end = 1'b0;
  logic        trc_valid = 1'b0;
  logic        trc_ready;
  logic [19:0] trc_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [19:0] rd_data;
  logic [7:0]  status_cnt;
  logic [7:0]  status_aux;
  logic [5:0]  oldest_idx;
  logic        armed;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  trace_ring_capture i_trace_ring_capture (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .arm_set(arm_set),
    .arm_clr(arm_clr), .align_end(align_end), .trc_valid(trc_valid),
    .trc_ready(trc_ready), .trc_data(trc_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .status_cnt(status_cnt), .status_aux(status_aux),
    .oldest_idx(oldest_idx), .armed(armed)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_arm(input logic mode);
    @(negedge clk);
    align_end = mode;
    arm_set = 1'b1;
    @(negedge clk);
    arm_set = 1'b0;
  endtask

  task automatic push_n(input int n, input logic [19:0] base);
    for (int i = 0; i < n; i++) begin
      trc_valid = 1'b1;
      trc_data  = base + 20'(i);
      @(negedge clk);
    end
    trc_valid = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int idx, input logic [19:0] exp);
    rd_addr = 6'(idx);
    #1;
    chk(req, 32'(rd_data), 32'(exp));
  endtask

  task automatic t_reset;
    chk("R9 cnt after por", 32'(status_cnt), 32'h00);
    chk("R9 armed after por", 32'(armed), 32'h0);
    chk("R2 ready when idle", 32'(trc_ready), 32'h0);
  endtask

  task automatic t_idle_ignored;
    push_n(3, 20'h0ABC);
    chk("R2 cnt unchanged when idle", 32'(status_cnt), 32'h00);
  endtask

  task automatic t_begin_fill;
    do_arm(1'b0);
    chk("R7 armed", 32'(armed), 32'h1);
    push_n(5, 20'h10000);
    chk("R1 R3 count after 5", 32'(status_cnt), 32'h05);
    rd_chk("R1 slot 4", 4, 20'h10004);
    push_n(59, 20'h10005);
    chk("R4 R3 full, cnt 0", 32'(status_cnt), 32'h80);
    chk("R11 aux mirrors full", 32'(status_aux), 32'h80);
    chk("R5 disarmed", 32'(armed), 32'h0);
    chk("R5 ready low", 32'(trc_ready), 32'h0);
    chk("R6 oldest idx", 32'(oldest_idx), 32'h0);
    push_n(2, 20'h0DEAD);
    chk("R5 cnt after extra", 32'(status_cnt), 32'h80);
    rd_chk("R5 slot 0 kept", 0, 20'h10000);
    rd_chk("R10 slot 63", 63, 20'h1003F);
    rd_chk("R10 slot 31", 31, 20'h1001F);
    chk("R10 cnt after reads", 32'(status_cnt), 32'h80);
  endtask

  task automatic t_end_wrap;
    do_arm(1'b1);
    chk("R7 cleared by arm", 32'(status_cnt), 32'h00);
    chk("R11 aux cleared", 32'(status_aux), 32'h00);
    push_n(70, 20'h20000);
    chk("R6 cnt after wrap", 32'(status_cnt), 32'h86);
    chk("R6 still armed", 32'(armed), 32'h1);
    chk("R6 oldest idx", 32'(oldest_idx), 32'h6);
    rd_chk("R6 slot 0 newest", 0, 20'h20040);
    rd_chk("R6 slot 5", 5, 20'h20045);
    rd_chk("R6 slot 6 oldest", 6, 20'h20006);
  endtask

  task automatic t_sys_reset;
    @(negedge clk);
    sys_rst_n = 1'b0;
    arm_set = 1'b1;
    @(negedge clk);
    @(negedge clk);
    arm_set = 1'b0;
    chk("R8 armed low in sysrst", 32'(armed), 32'h0);
    sys_rst_n = 1'b1;
    @(negedge clk);
    chk("R8 cnt kept", 32'(status_cnt), 32'h86);
    rd_chk("R8 data kept", 3, 20'h20043);
    chk("R8 disarmed", 32'(armed), 32'h0);
  endtask

  task automatic t_arm_clr;
    do_arm(1'b1);
    push_n(3, 20'h30000);
    @(negedge clk);
    arm_clr = 1'b1;
    @(negedge clk);
    arm_clr = 1'b0;
    chk("R7 arm_clr disarms", 32'(armed), 32'h0);
    chk("R7 cnt kept", 32'(status_cnt), 32'h03);
    chk("R6 oldest 0 when not full", 32'(oldest_idx), 32'h0);
    push_n(2, 20'h0BEEF);
    chk("R2 cnt held", 32'(status_cnt), 32'h03);
    rd_chk("R2 slot 3 untouched", 3, 20'h20043);
  endtask

  task automatic t_por;
    push_n(0, 20'h0);
    do_arm(1'b1);
    push_n(64, 20'h40000);
    chk("R4 full before por", 32'(status_cnt), 32'h80);
    @(negedge clk);
    por_n = 1'b0;
    #1;
    chk("R9 cnt cleared", 32'(status_cnt), 32'h00);
    chk("R9 armed cleared", 32'(armed), 32'h0);
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    sys_rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_ignored();
    t_begin_fill();
    t_end_wrap();
    t_sys_reset();
    t_arm_clr();
    t_por();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule